// File: doc/BRIEF.md
# Free-Running Time-Base Counter

This block keeps a monotonic time base: a counter twice the register-bus width (64 bits at the default 32-bit bus). It advances by one on every clock cycle in which the general-configuration count-enable bit is set. There is no divider between the clock and the counter. Nothing else in the chip resets or reloads it; only the block reset does.

Software reads the value as two bus words. The low word is read first. That read also copies the high half of the same counter value into a shadow register. The read of the high word that follows returns the shadow, so the two halves describe one instant even when a carry crosses between them. Writes are accepted on the bus and discarded.

Top module: `sys_time_counter`

## Requirements
- R1: The count spans 2*BUS_W bits. It is never saturated and wraps to zero modulo 2^(2*BUS_W), with the carry from the low half into the high half taking effect in the same step.
- R2: While `cfg_count_en` is 0 the count holds its value.
- R3: Reset clears the count to 0. Each clock cycle with `cfg_count_en` = 1 adds exactly one.
- R4: A read at byte address LO_ADDR (default 0x0) is answered one cycle later. `rd_valid` is 1 and `rd_data` equals bits [BUS_W-1:0] of the count as it stood at the clock edge that sampled the request.
- R5: A read at LO_ADDR also loads bits [2*BUS_W-1:BUS_W] of that same count value into a shadow. A read at HI_ADDR (default 0x4) returns the shadow one cycle later with `rd_valid` = 1. The shadow changes only on a low-word read, so repeated high-word reads return the same word.
- R6: A write (`req_valid` = 1, `req_write` = 1) at any address changes neither the count nor the shadow, and it produces no `rd_valid`.
- R7: A read at any address other than LO_ADDR and HI_ADDR returns 0 with `rd_valid` = 1.
- R8: After reset, `rd_valid` is 0, `rd_data` is 0 and the shadow is 0. `rd_data` holds its last value in cycles without a read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_count_en | input | 1 | Count-enable bit from the general configuration word |
| req_valid | input | 1 | Register access request strobe |
| req_write | input | 1 | 1 = write (discarded), 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| rd_valid | output | 1 | Read response valid, one cycle after the request |
| rd_data | output | BUS_W | Read response data |

## Verification
The bench builds the block with BUS_W = 8, which gives a 16-bit count. At that width the low half carries into the high half every 256 enabled cycles, and the whole count wraps to zero after 65536 cycles. Both events are therefore reachable in a short run. Low/high read pairs are interleaved across many carries so that the shadow coherence check meets the carry boundary. A separate phase continues past the full wrap, so the R1 wrap behaviour is checked on real values.

// File: rtl/stc_pkg.sv
package stc_pkg;

   // Kind of bus access seen in the current cycle
   typedef enum logic [2:0] {
      ACC_IDLE     = 3'd0,
      ACC_LO       = 3'd1,
      ACC_HI       = 3'd2,
      ACC_UNMAPPED = 3'd3,
      ACC_WRITE    = 3'd4
   } acc_e;

endpackage

// File: rtl/stc_count.sv
module stc_count #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   output logic [CNT_W-1:0] cnt_o
);

   initial begin
      assert (CNT_W >= 2) else $error("stc_count: CNT_W too small");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (en_i) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o = cnt_q;

   // R2: disabled cycle leaves the count untouched
   p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> cnt_q == $past(cnt_q));

   // R3 / R1: enabled cycle adds one, modulo the full width
   p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/stc_shadow.sv
module stc_shadow #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_i,
   input  logic [W-1:0] hi_i,
   output logic [W-1:0] shadow_o
);

   logic [W-1:0] shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     shadow_q <= '0;
      else if (cap_i) shadow_q <= hi_i;
   end

   assign shadow_o = shadow_q;

   // R5 / R6: shadow moves only on a low-word read
   p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(shadow_q));

   // R5: captured word is the high half presented at the capture edge
   p_shadow_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> shadow_q == $past(hi_i));

endmodule

// File: rtl/stc_rdport.sv
module stc_rdport
   import stc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  acc_e         acc_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] shadow_i,
   output logic         rd_valid_o,
   output logic [W-1:0] rd_data_o
);

   logic         valid_q;
   logic [W-1:0] data_q;
   logic         is_read;
   logic [W-1:0] data_d;

   always_comb begin
      is_read = 1'b0;
      data_d  = data_q;
      unique case (acc_i)
         ACC_LO:       begin is_read = 1'b1; data_d = lo_i;     end
         ACC_HI:       begin is_read = 1'b1; data_d = shadow_i; end
         ACC_UNMAPPED: begin is_read = 1'b1; data_d = '0;       end
         default:      begin is_read = 1'b0; data_d = data_q;   end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= is_read;
         data_q  <= data_d;
      end
   end

   assign rd_valid_o = valid_q;
   assign rd_data_o  = data_q;

   // R4: low-word read answers next cycle with the low half
   p_lo_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_i == ACC_LO |=> valid_q && data_q == $past(lo_i));

   // R5: high-word read returns the shadow
   p_hi_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_i == ACC_HI |=> valid_q && data_q == $past(shadow_i));

   // R7: unmapped read returns zero
   p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc_i == ACC_UNMAPPED |=> valid_q && data_q == '0);

   // R6 / R8: no response and held data without a read
   p_no_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i == ACC_WRITE || acc_i == ACC_IDLE) |=> !valid_q && $stable(data_q));

endmodule

// File: rtl/sys_time_counter.sv
module sys_time_counter
   import stc_pkg::*;
#(
   parameter int          BUS_W   = 32,
   parameter int          ADDR_W  = 4,
   parameter logic [31:0] LO_ADDR = 32'h0,
   parameter logic [31:0] HI_ADDR = 32'h4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_count_en,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rd_valid,
   output logic [BUS_W-1:0]  rd_data
);

   localparam int CNT_W = 2 * BUS_W;
   localparam int WORDS = CNT_W / BUS_W;

   initial begin
      assert (BUS_W >= 1) else $error("sys_time_counter: BUS_W must be positive");
      assert (ADDR_W >= 1 && ADDR_W <= 32) else $error("sys_time_counter: ADDR_W out of range");
      assert (LO_ADDR != HI_ADDR) else $error("sys_time_counter: word addresses collide");
      assert ((LO_ADDR >> ADDR_W) == 0 && (HI_ADDR >> ADDR_W) == 0)
         else $error("sys_time_counter: word address does not fit ADDR_W");
   end

   logic [CNT_W-1:0] cnt;
   logic [BUS_W-1:0] word [WORDS];
   logic [BUS_W-1:0] shadow;
   acc_e             acc;

   // Split the count into bus-sized words
   for (genvar g = 0; g < WORDS; g++) begin : g_word
      assign word[g] = cnt[g*BUS_W +: BUS_W];
   end

   always_comb begin
      if (!req_valid)                           acc = ACC_IDLE;
      else if (req_write)                       acc = ACC_WRITE;
      else if (req_addr == ADDR_W'(LO_ADDR))    acc = ACC_LO;
      else if (req_addr == ADDR_W'(HI_ADDR))    acc = ACC_HI;
      else                                      acc = ACC_UNMAPPED;
   end

   stc_count #(.CNT_W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (cfg_count_en),
      .cnt_o (cnt)
   );

   stc_shadow #(.W(BUS_W)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_i    (acc == ACC_LO),
      .hi_i     (word[WORDS-1]),
      .shadow_o (shadow)
   );

   stc_rdport #(.W(BUS_W)) u_rdport (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_i      (acc),
      .lo_i       (word[0]),
      .shadow_i   (shadow),
      .rd_valid_o (rd_valid),
      .rd_data_o  (rd_data)
   );

   // R6: a write leaves the count on its normal path
   p_write_no_touch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && !cfg_count_en) |=> cnt == $past(cnt));

endmodule

// File: tb/sys_time_counter_bench.sv
module sys_time_counter_bench;

   localparam int BUS_W  = 8;
   localparam int ADDR_W = 4;
   localparam int CNT_W  = 2 * BUS_W;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cfg_count_en;
   logic              req_valid;
   logic              req_write;
   logic [ADDR_W-1:0] req_addr;
   logic              rd_valid;
   logic [BUS_W-1:0]  rd_data;

   int    n_run  = 0;
   int    n_fail = 0;
   string tag    = "R8";

   // Reference model state
   longint unsigned m_cnt = 0;
   logic [BUS_W-1:0] m_sh = '0;
   logic             e_valid = 1'b0;
   logic [BUS_W-1:0] e_data = '0;
   int               cycles = 0;

   always #2 clk = ~clk;

   sys_time_counter #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_sys_time_counter (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_count_en (cfg_count_en),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .rd_valid     (rd_valid),
      .rd_data      (rd_data)
   );

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (!rst_n) begin
         m_cnt   = 0;
         m_sh    = '0;
         e_valid = 1'b0;
         e_data  = '0;
      end else begin
         e_valid = req_valid && !req_write;
         if (e_valid) begin
            if (req_addr == 4'h0) begin
               e_data = BUS_W'(m_cnt);
               m_sh   = BUS_W'(m_cnt >> BUS_W);
            end else if (req_addr == 4'h4) begin
               e_data = m_sh;
            end else begin
               e_data = '0;
            end
         end
         if (cfg_count_en) m_cnt = m_cnt + 1;
      end
   end

   // Compare on every falling edge
   always @(negedge clk) begin
      n_run = n_run + 1;
      if (rd_valid !== e_valid) begin
         n_fail = n_fail + 1;
         $display("FAIL %s rd_valid actual=%0b expected=%0b", tag, rd_valid, e_valid);
      end
      if (e_valid) begin
         n_run = n_run + 1;
         if (rd_data !== e_data) begin
            n_fail = n_fail + 1;
            $display("FAIL %s rd_data actual=%0h expected=%0h", tag, rd_data, e_data);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         req_write = 1'b0;
      end
   endtask

   task automatic acc(input logic wr, input logic [ADDR_W-1:0] a);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
   endtask

   initial begin
      rst_n = 1'b0; cfg_count_en = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      // R8: reset state at the ports
      n_run = n_run + 1;
      if (rd_data !== '0 || rd_valid !== 1'b0) begin
         n_fail = n_fail + 1;
         $display("FAIL R8 reset outputs actual=%0h/%0b expected=0/0", rd_data, rd_valid);
      end
      acc(1'b0, 4'h4);              // R8: shadow reads 0 before any low read
      idle(1);

      tag = "R3"; cfg_count_en = 1'b1;
      idle(7);
      acc(1'b0, 4'h0); acc(1'b0, 4'h0); idle(3); acc(1'b0, 4'h0);

      tag = "R4";
      for (int k = 0; k < 6; k++) begin acc(1'b0, 4'h0); idle(k); end

      tag = "R5";
      acc(1'b0, 4'h0); idle(300); acc(1'b0, 4'h4); acc(1'b0, 4'h4);

      tag = "R2"; cfg_count_en = 1'b0;
      idle(20); acc(1'b0, 4'h0); idle(10); acc(1'b0, 4'h0); acc(1'b0, 4'h4);
      cfg_count_en = 1'b1;

      tag = "R6";
      acc(1'b1, 4'h0); acc(1'b1, 4'h4); acc(1'b1, 4'h8);
      acc(1'b0, 4'h4); acc(1'b0, 4'h0); acc(1'b1, 4'h0); acc(1'b0, 4'h4);

      tag = "R7";
      acc(1'b0, 4'h8); acc(1'b0, 4'hC); acc(1'b0, 4'h1); idle(1);

      // R1 and R5 across carries and the full wrap
      tag = "R1";
      while (m_cnt < (64'd1 << CNT_W) + 600) begin
         acc(1'b0, 4'h0); acc(1'b0, 4'h4); idle(97);
      end
      acc(1'b0, 4'h0); acc(1'b0, 4'h4);
      idle(3);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      wait (cycles >= 190000);
      n_run  = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL %s watchdog actual=%0d cycles expected=finish", tag, cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule